// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home agent for a set of memory blocks shared by four caches. For every block it keeps a directory entry: one presence flag per cache, a dirty/exclusive flag, and a small amount of transaction state. Caches send read and read-for-ownership requests on a valid/ready request port. The block looks up the entry for the requested block and answers on a response port. The answer is a shared or exclusive data grant, a stream of invalidations, a revoke to the current owner, or a refusal that tells the requester to retry.

An entry with an invalidation round or a revoke still open is busy, and any request to it is refused until the round closes. A revoked owner sends the data straight to the requester, so home only sees the owner's completion message. The completion message and the invalidation acknowledgements arrive on a separate, always-accepted acknowledgement port. The block keeps no data itself. Memory, the network and the caches sit outside it.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every entry holds no copies and is clean and idle, `rsp_valid` is low, and `req_ready` is high.
- R2: A request is a read (op 0) or a read-for-ownership (op 1). When it reaches a non-busy, non-dirty block that no other cache holds, the cycle after acceptance brings an exclusive grant (response op 2) to the requester. The entry then holds only the requester and is dirty.
- R3: A read (op 0) to a clean block that another cache holds yields a shared grant (response op 1) and adds the requester to the holders.
- R4: A read-for-ownership to a clean block held by other caches sends one invalidation (response op 3) to each other holder. These go out in ascending cache id, one per cycle, starting two cycles after acceptance. The entry becomes busy, holds only the requester, and is dirty.
- R5: The cycle after the final invalidation acknowledgement (ack op 2) is taken, home sends an exclusive grant (response op 2) to the waiting requester, and the entry stops being busy.
- R6: A read to a block that is dirty at another cache sends a shared revoke (response op 4) to the owner, with `rsp_fwd` naming the requester. When the owner's revoke-done (ack op 3) arrives, the entry holds both caches, is clean, and is no longer busy. Home sends no data.
- R7: A read-for-ownership to a block dirty at another cache sends an exclusive revoke (response op 5) to the owner, with `rsp_fwd` naming the requester. After the revoke-done the entry holds only the requester, dirty.
- R8: Any request to a busy block receives a refusal (response op 6) and leaves the entry unchanged.
- R9: `req_ready` is low while invalidations are still being issued, and in any cycle in which a final invalidation acknowledgement is presented.
- R10: An acknowledgement is ignored if it targets an idle block, if its type does not match the open round, or if it is a revoke-done from a cache other than the owner.
- R11: A request from the cache that already holds the block dirty is answered at once with an exclusive grant, and no other message is sent.
- R12: Blocks are independent: a busy block does not delay or change the handling of requests to other blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request taken at this edge when valid |
| req_op | input | 3 | 0 read, 1 read-for-ownership |
| req_src | input | 2 | Requesting cache id |
| req_blk | input | 4 | Block index |
| ack_valid | input | 1 | Acknowledgement present (always taken) |
| ack_op | input | 3 | 2 invalidation ack, 3 revoke-done |
| ack_src | input | 2 | Acknowledging cache id |
| ack_blk | input | 4 | Block index |
| rsp_valid | output | 1 | Response present |
| rsp_op | output | 3 | 1 shared grant, 2 exclusive grant, 3 invalidate, 4 shared revoke, 5 exclusive revoke, 6 refuse |
| rsp_dst | output | 2 | Destination cache id |
| rsp_blk | output | 4 | Block index |
| rsp_fwd | output | 2 | Requester the owner forwards to (revokes only, else 0) |

## Verification
The bench aims at the places where ordering matters. A request arrives while invalidations are still leaving: a design that did not stall would drop one invalidation or answer the request on top of it. A final acknowledgement lands in the same cycle as a waiting request: a design without priority would lose the deferred grant. A request hits a block with an open revoke: a design without the busy check would grant a second owner. Stray acknowledgements are also sent, wrong type, idle block, or non-owner, and they must not close a round early. Without that filter, home would grant exclusive while a sharer still holds a copy.

// File: rtl/dir_pkg.sv
package dir_pkg;

    parameter int NCACHE = 4;
    parameter int NBLK   = 16;

    localparam int CW = $clog2(NCACHE);
    localparam int BW = $clog2(NBLK);
    localparam int PW = $clog2(NCACHE + 1);

    typedef enum logic [2:0] {
        I_RD       = 3'd0,
        I_RDX      = 3'd1,
        I_INV_ACK  = 3'd2,
        I_REV_DONE = 3'd3
    } in_op_e;

    typedef enum logic [2:0] {
        R_NONE    = 3'd0,
        R_DAT_SHR = 3'd1,
        R_DAT_EXC = 3'd2,
        R_INV     = 3'd3,
        R_REV_SH  = 3'd4,
        R_REV_EX  = 3'd5,
        R_NACK    = 3'd6
    } rsp_op_e;

    typedef enum logic [1:0] {
        W_INV = 2'd0,
        W_RSH = 2'd1,
        W_REX = 2'd2
    } wait_e;

    typedef struct packed {
        logic [NCACHE-1:0] pres;
        logic              dirty;
        logic              busy;
        logic [PW-1:0]     pend;
        logic [CW-1:0]     waiter;
        wait_e             kind;
    } dir_ent_t;

    typedef struct packed {
        logic          valid;
        rsp_op_e       op;
        logic [CW-1:0] dst;
        logic [BW-1:0] blk;
        logic [CW-1:0] fwd;
    } rsp_t;

    function automatic logic [CW-1:0] lowest_idx(input logic [NCACHE-1:0] m);
        logic [CW-1:0] r;
        r = '0;
        for (int i = NCACHE - 1; i >= 0; i--) begin
            if (m[i]) r = CW'(i);
        end
        return r;
    endfunction

    function automatic logic [PW-1:0] count_ones(input logic [NCACHE-1:0] m);
        logic [PW-1:0] c;
        c = '0;
        for (int i = 0; i < NCACHE; i++) begin
            if (m[i]) c = c + PW'(1);
        end
        return c;
    endfunction

    function automatic logic [NCACHE-1:0] onehot(input logic [CW-1:0] id);
        logic [NCACHE-1:0] o;
        o = '0;
        o[id] = 1'b1;
        return o;
    endfunction

endpackage

// File: rtl/dir_entry_bank.sv
module dir_entry_bank
    import dir_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          we_a,
    input  logic [BW-1:0] idx_a,
    input  dir_ent_t      dat_a,
    input  logic          we_b,
    input  logic [BW-1:0] idx_b,
    input  dir_ent_t      dat_b,
    input  logic [BW-1:0] rd_idx_a,
    input  logic [BW-1:0] rd_idx_b,
    output dir_ent_t      rd_a,
    output dir_ent_t      rd_b
);

    dir_ent_t ents [NBLK];

    always_ff @(posedge clk) begin
        for (int g = 0; g < NBLK; g++) begin
            if (rst) begin
                ents[g] <= '0;
            end else if (we_a && idx_a == BW'(g)) begin
                ents[g] <= dat_a;
            end else if (we_b && idx_b == BW'(g)) begin
                ents[g] <= dat_b;
            end
        end
    end

    assign rd_a = ents[rd_idx_a];
    assign rd_b = ents[rd_idx_b];

    AST_WRITE_PORTS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        (we_a && we_b) |-> (idx_a != idx_b)); // R12

endmodule

// File: rtl/dir_inv_seq.sv
module dir_inv_seq
    import dir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [NCACHE-1:0] load_mask,
    input  logic [BW-1:0]     load_blk,
    input  logic              adv,
    output logic              active,
    output logic [CW-1:0]     tgt,
    output logic [BW-1:0]     blk
);

    logic [NCACHE-1:0] mask_q;
    logic [BW-1:0]     blk_q;

    assign active = |mask_q;
    assign tgt    = lowest_idx(mask_q);
    assign blk    = blk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            blk_q  <= '0;
        end else if (load) begin
            mask_q <= load_mask;
            blk_q  <= load_blk;
        end else if (adv) begin
            mask_q[tgt] <= 1'b0;
        end
    end

    AST_NO_LOAD_WHILE_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        load |-> !active); // R9

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dir_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [2:0]    req_op,
    input  logic [CW-1:0] req_src,
    input  logic [BW-1:0] req_blk,
    input  logic          ack_valid,
    input  logic [2:0]    ack_op,
    input  logic [CW-1:0] ack_src,
    input  logic [BW-1:0] ack_blk,
    output logic          rsp_valid,
    output logic [2:0]    rsp_op,
    output logic [CW-1:0] rsp_dst,
    output logic [BW-1:0] rsp_blk,
    output logic [CW-1:0] rsp_fwd
);

    dir_ent_t e_req, e_ack, n_req, n_ack;
    logic     we_req, we_ack;

    logic              seq_load, seq_adv, seq_active;
    logic [CW-1:0]     seq_tgt;
    logic [BW-1:0]     seq_blk;

    logic              is_req, req_fire, ack_hit, ack_last, fin_rsp;
    logic [CW-1:0]     owner;
    logic [NCACHE-1:0] src_oh, others;
    logic              excl_self, excl_other;
    rsp_t              rsp_n, rsp_q;

    dir_entry_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .we_a     (we_ack),
        .idx_a    (ack_blk),
        .dat_a    (n_ack),
        .we_b     (we_req),
        .idx_b    (req_blk),
        .dat_b    (n_req),
        .rd_idx_a (ack_blk),
        .rd_idx_b (req_blk),
        .rd_a     (e_ack),
        .rd_b     (e_req)
    );

    dir_inv_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (seq_load),
        .load_mask (others),
        .load_blk  (req_blk),
        .adv       (seq_adv),
        .active    (seq_active),
        .tgt       (seq_tgt),
        .blk       (seq_blk)
    );

    // acknowledgement path
    always_comb begin
        ack_hit = ack_valid && e_ack.busy &&
                  (((ack_op == I_INV_ACK) && (e_ack.kind == W_INV)) ||
                   ((ack_op == I_REV_DONE) && (e_ack.kind != W_INV) &&
                    (ack_src == lowest_idx(e_ack.pres))));
        ack_last = ack_hit && (e_ack.pend == PW'(1));
        fin_rsp  = ack_last && (e_ack.kind == W_INV);
        we_ack   = ack_hit;
        n_ack    = e_ack;
        if (ack_hit) begin
            n_ack.pend = e_ack.pend - PW'(1);
            if (ack_last) begin
                n_ack.busy = 1'b0;
                case (e_ack.kind)
                    W_RSH: begin
                        n_ack.pres  = e_ack.pres | onehot(e_ack.waiter);
                        n_ack.dirty = 1'b0;
                    end
                    W_REX: begin
                        n_ack.pres  = onehot(e_ack.waiter);
                        n_ack.dirty = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // request path and response selection
    always_comb begin
        seq_adv    = seq_active && !fin_rsp;
        req_ready  = !seq_active && !fin_rsp;
        req_fire   = req_valid && req_ready;
        is_req     = (req_op == I_RD) || (req_op == I_RDX);
        src_oh     = onehot(req_src);
        owner      = lowest_idx(e_req.pres);
        others     = e_req.pres & ~src_oh;
        excl_self  = e_req.dirty && (owner == req_src);
        excl_other = e_req.dirty && (owner != req_src);

        rsp_n    = '0;
        n_req    = e_req;
        we_req   = 1'b0;
        seq_load = 1'b0;

        if (fin_rsp) begin
            rsp_n.valid = 1'b1;
            rsp_n.op    = R_DAT_EXC;
            rsp_n.dst   = e_ack.waiter;
            rsp_n.blk   = ack_blk;
        end else if (seq_active) begin
            rsp_n.valid = 1'b1;
            rsp_n.op    = R_INV;
            rsp_n.dst   = seq_tgt;
            rsp_n.blk   = seq_blk;
        end else if (req_fire && is_req) begin
            rsp_n.valid = 1'b1;
            rsp_n.dst   = req_src;
            rsp_n.blk   = req_blk;
            if (e_req.busy) begin
                rsp_n.op = R_NACK;
            end else if (excl_self) begin
                rsp_n.op = R_DAT_EXC;
            end else if (excl_other) begin
                rsp_n.op     = (req_op == I_RD) ? R_REV_SH : R_REV_EX;
                rsp_n.dst    = owner;
                rsp_n.fwd    = req_src;
                we_req       = 1'b1;
                n_req.busy   = 1'b1;
                n_req.pend   = PW'(1);
                n_req.waiter = req_src;
                n_req.kind   = (req_op == I_RD) ? W_RSH : W_REX;
            end else if (others == '0) begin
                rsp_n.op    = R_DAT_EXC;
                we_req      = 1'b1;
                n_req.pres  = src_oh;
                n_req.dirty = 1'b1;
            end else if (req_op == I_RD) begin
                rsp_n.op   = R_DAT_SHR;
                we_req     = 1'b1;
                n_req.pres = e_req.pres | src_oh;
            end else begin
                rsp_n.valid  = 1'b0;
                seq_load     = 1'b1;
                we_req       = 1'b1;
                n_req.pres   = src_oh;
                n_req.dirty  = 1'b1;
                n_req.busy   = 1'b1;
                n_req.pend   = count_ones(others);
                n_req.waiter = req_src;
                n_req.kind   = W_INV;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rsp_q <= '0;
        else     rsp_q <= rsp_n;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_op    = rsp_q.op;
    assign rsp_dst   = rsp_q.dst;
    assign rsp_blk   = rsp_q.blk;
    assign rsp_fwd   = rsp_q.fwd;

    AST_NACK_ON_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_fire && is_req && e_req.busy) |=> (rsp_valid && rsp_op == R_NACK)); // R8
    AST_EXCL_SINGLE_HOLDER: assert property (@(posedge clk) disable iff (rst)
        e_req.dirty |-> ($countones(e_req.pres) == 1)); // R2
    AST_BUSY_HAS_PENDING: assert property (@(posedge clk) disable iff (rst)
        e_req.busy |-> (e_req.pend != '0)); // R4

endmodule

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb;
    import dir_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [2:0]    req_op = '0;
    logic [CW-1:0] req_src = '0;
    logic [BW-1:0] req_blk = '0;
    logic          ack_valid = 1'b0;
    logic [2:0]    ack_op = '0;
    logic [CW-1:0] ack_src = '0;
    logic [BW-1:0] ack_blk = '0;
    logic          rsp_valid;
    logic [2:0]    rsp_op;
    logic [CW-1:0] rsp_dst;
    logic [BW-1:0] rsp_blk;
    logic [CW-1:0] rsp_fwd;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dir_home_ctrl u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_src(req_src), .req_blk(req_blk),
        .ack_valid(ack_valid), .ack_op(ack_op), .ack_src(ack_src), .ack_blk(ack_blk),
        .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_dst(rsp_dst),
        .rsp_blk(rsp_blk), .rsp_fwd(rsp_fwd)
    );

    int n_chk = 0;
    int n_err = 0;

    // behavioural reference state
    int m_pres [NBLK];
    bit m_dirty [NBLK];
    bit m_busy [NBLK];
    int m_pend [NBLK];
    int m_waiter [NBLK];
    int m_kind [NBLK];   // 0 invalidation round, 1 shared revoke, 2 exclusive revoke
    int invq [$];
    int inv_blk;
    bit m_acc;
    bit e_v;
    int e_op, e_dst, e_blk, e_fwd;
    string e_tag = "R1";

    function automatic int low(int m);
        for (int i = 0; i < NCACHE; i++) if (m[i]) return i;
        return 0;
    endfunction

    function automatic int cnt(int m);
        int c = 0;
        for (int i = 0; i < NCACHE; i++) if (m[i]) c++;
        return c;
    endfunction

    function automatic bit ack_matches();
        int b = int'(ack_blk);
        if (!ack_valid || !m_busy[b]) return 0;
        if (int'(ack_op) == 2 && m_kind[b] == 0) return 1;
        if (int'(ack_op) == 3 && m_kind[b] != 0 && int'(ack_src) == low(m_pres[b])) return 1;
        return 0;
    endfunction

    function automatic bit final_inv_ack();
        int b = int'(ack_blk);
        return ack_matches() && m_pend[b] == 1 && m_kind[b] == 0;
    endfunction

    function automatic bit ready_now();
        return invq.size() == 0 && !final_inv_ack();
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBLK; i++) begin
                m_pres[i] = 0; m_dirty[i] = 0; m_busy[i] = 0;
                m_pend[i] = 0; m_waiter[i] = 0; m_kind[i] = 0;
            end
            invq.delete();
            m_acc = 0; e_v = 0; e_tag = "R1";
        end else begin
            bit hit, last, fin, rdy;
            int ab, b, s, own, oth;
            bit nv; int nop, ndst, nblk, nfwd; string ntag;
            ab = int'(ack_blk);
            hit = ack_matches();
            last = hit && m_pend[ab] == 1;
            fin = final_inv_ack();
            rdy = invq.size() == 0 && !fin;
            nv = 0; nop = 0; ndst = 0; nblk = 0; nfwd = 0; ntag = "R10";
            m_acc = req_valid && rdy;
            if (fin) begin
                nv = 1; nop = 2; ndst = m_waiter[ab]; nblk = ab; ntag = "R5";
            end else if (invq.size() != 0) begin
                nv = 1; nop = 3; ndst = invq.pop_front(); nblk = inv_blk; ntag = "R4";
            end else if (m_acc && (int'(req_op) == 0 || int'(req_op) == 1)) begin
                b = int'(req_blk); s = int'(req_src);
                own = low(m_pres[b]);
                oth = m_pres[b] & ~(1 << s);
                nv = 1; ndst = s; nblk = b;
                if (m_busy[b]) begin
                    nop = 6; ntag = "R8";
                end else if (m_dirty[b] && own == s) begin
                    nop = 2; ntag = "R11";
                end else if (m_dirty[b]) begin
                    nop = (int'(req_op) == 0) ? 4 : 5;
                    ntag = (int'(req_op) == 0) ? "R6" : "R7";
                    ndst = own; nfwd = s;
                    m_busy[b] = 1; m_pend[b] = 1; m_waiter[b] = s;
                    m_kind[b] = (int'(req_op) == 0) ? 1 : 2;
                end else if (oth == 0) begin
                    nop = 2; ntag = "R2";
                    m_pres[b] = 1 << s; m_dirty[b] = 1;
                end else if (int'(req_op) == 0) begin
                    nop = 1; ntag = "R3";
                    m_pres[b] = m_pres[b] | (1 << s);
                end else begin
                    nv = 0;
                    for (int i = 0; i < NCACHE; i++) if (oth[i]) invq.push_back(i);
                    inv_blk = b;
                    m_pres[b] = 1 << s; m_dirty[b] = 1; m_busy[b] = 1;
                    m_pend[b] = cnt(oth); m_waiter[b] = s; m_kind[b] = 0;
                end
            end
            if (hit) begin
                m_pend[ab]--;
                if (last) begin
                    m_busy[ab] = 0;
                    if (m_kind[ab] == 1) begin
                        m_pres[ab] = m_pres[ab] | (1 << m_waiter[ab]); m_dirty[ab] = 0;
                    end else if (m_kind[ab] == 2) begin
                        m_pres[ab] = 1 << m_waiter[ab]; m_dirty[ab] = 1;
                    end
                end
            end
            e_v = nv; e_op = nop; e_dst = ndst; e_blk = nblk; e_fwd = nfwd; e_tag = ntag;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            chk(e_tag, "rsp_valid", int'(rsp_valid), int'(e_v));
            if (e_v) begin
                chk(e_tag, "rsp_op", int'(rsp_op), e_op);
                chk(e_tag, "rsp_dst", int'(rsp_dst), e_dst);
                chk(e_tag, "rsp_blk", int'(rsp_blk), e_blk);
                chk(e_tag, "rsp_fwd", int'(rsp_fwd), e_fwd);
            end
            chk("R9", "req_ready", int'(req_ready), int'(ready_now()));
        end
    end

    task automatic step(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic send_req(int op, int src, int blk);
        req_valid = 1'b1; req_op = 3'(op); req_src = CW'(src); req_blk = BW'(blk);
        do begin @(posedge clk); #1; end while (!m_acc);
        req_valid = 1'b0;
    endtask

    task automatic send_ack(int op, int src, int blk);
        ack_valid = 1'b1; ack_op = 3'(op); ack_src = CW'(src); ack_blk = BW'(blk);
        @(posedge clk); #1;
        ack_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        #2;
        chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
        chk("R1", "req_ready after reset", int'(req_ready), 1);
        step(1);
        send_req(0, 0, 1); step(1);          // R2 uncached read -> exclusive
        send_req(0, 0, 1); step(1);          // R11 owner re-reads
        send_req(0, 1, 1); step(1);          // R6 shared revoke to cache 0
        send_req(0, 2, 1); step(1);          // R8 busy block refused
        send_req(1, 3, 2); step(1);          // R12 other block served, R2 with ownership
        send_ack(3, 2, 1); step(1);          // R10 revoke-done from non-owner ignored
        send_req(0, 3, 1); step(1);          // R8 still busy
        send_ack(3, 0, 1); step(1);          // R6 owner done
        send_req(0, 2, 1); step(1);          // R3 shared grant
        send_req(0, 3, 1); step(1);          // R3 shared grant
        send_ack(2, 0, 1); step(1);          // R10 ack to idle block
        send_req(1, 2, 1);                   // R4 invalidate 0,1,3
        fork
            begin
                step(4);
                send_ack(2, 0, 1);
                send_ack(2, 1, 1);
                send_ack(3, 2, 1);           // R10 wrong type ignored
                send_ack(2, 3, 1);           // R5 final ack
            end
            begin
                step(1);
                send_req(0, 0, 5);           // R9 stalled by invalidations and final ack
            end
        join
        step(2);
        send_req(1, 1, 1); step(1);          // R7 exclusive revoke to cache 2
        send_ack(3, 2, 1); step(1);
        send_req(0, 1, 1); step(1);          // R11
        send_req(1, 1, 1); step(1);          // R11
        send_req(1, 3, 7); step(1);          // R2
        send_req(0, 2, 5); step(1);          // R6 on block 5 owned by cache 0
        send_ack(3, 0, 5); step(1);
        send_req(1, 1, 5);                   // R4 invalidate 0 and 2
        step(3);
        send_ack(2, 0, 5);
        send_ack(2, 2, 5);                   // R5
        step(3);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog R9 actual=hung expected=done");
        finish_run();
    end

endmodule